// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block decides whether the destination address of an incoming multicast frame falls into one of the groups a host has subscribed to. The address arrives as a byte stream, one byte per clock while a valid strobe is high. A start strobe opens each frame. The block runs a CRC-32 over the address bytes, one byte per clock, using an unrolled eight-step combinational update. From the complemented result it derives a 6-bit bucket number and looks that number up in a 64-entry bit table.

The bit table is supplied as two 32-bit words. Software builds it by setting the bit of every bucket that a wanted group address maps to. A mode input that selects gigabit operation shortens the hashed span from six address bytes to the first five. The block raises a one-cycle done strobe with the bucket number. At the same time the match output shows the table bit for that bucket. Further bytes of the frame are ignored until the next start.

Top module: `mcast_hash_filter`

## Requirements
- R1: While reset is held and after it is released, with no frame yet opened, done_o is 0 and idx_o is 0.
- R2: After a start, the CRC register holds 0xFFFFFFFF. Each byte updates it in eight steps, least significant data bit first. In each step the feedback bit is CRC bit 31 XOR the data bit, the register shifts left by one, and the result is XORed with 0x04C11DB7 when the feedback bit is 1.
- R3: After the last hashed byte, the CRC is complemented. Bits 31..24 of the complemented value are bit-reversed, and bits 7..2 of the reversed byte form idx_o, with bit 7 as the most significant bit. So idx_o[5] is complemented CRC bit 24 and idx_o[0] is complemented CRC bit 29.
- R4: With giga_i low at start, six bytes are hashed. With giga_i high at start, only the first five are hashed.
- R5: giga_i is captured on the start cycle. Changing it later in the frame does not change how many bytes are hashed.
- R6: done_o goes high for exactly one cycle. That cycle follows the clock edge that accepts the last hashed byte. done_o stays low before that cycle, and idx_o changes only when done_o rises.
- R7: Bytes offered after the last hashed byte, and before the next start, are ignored. No further done_o pulse appears and idx_o keeps its value.
- R8: match_o is bit idx_o of tbl_lo_i when idx_o is 0..31, and bit idx_o-32 of tbl_hi_i when idx_o is 32..63.
- R9: A start discards any frame in progress. A byte offered in the same cycle as start is dropped, and the first byte accepted is the one that follows.
- R10: Cycles with valid_i low are gaps. They are not hashed and do not count as bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new frame and reseeds the CRC |
| valid_i | input | 1 | byte_i carries an address byte this cycle |
| byte_i | input | 8 | Destination address byte, first byte of the address first |
| giga_i | input | 1 | Gigabit mode; when high, five bytes are hashed instead of six |
| tbl_lo_i | input | 32 | Hash table word for buckets 0 to 31 |
| tbl_hi_i | input | 32 | Hash table word for buckets 32 to 63 |
| idx_o | output | 6 | Bucket number of the last completed frame |
| done_o | output | 1 | One-cycle strobe: idx_o and match_o are fresh |
| match_o | output | 1 | Table bit selected by idx_o |

## Verification
The bench builds the block with its default parameters: a 32-bit table word and hashed lengths of six and five bytes. These values make both hashed lengths and both table words reachable. Many address patterns are swept, so bucket numbers land in the lower and the upper word. Each one is checked against one-hot and inverted tables. Gaps, restarts, a start together with a valid byte, and a mode change partway through a frame exercise the byte counting at its edges.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int unsigned CRC_W  = 32;
   localparam int unsigned BYTE_W = 8;
   typedef logic [CRC_W-1:0]  crc_t;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
   import mhf_pkg::*;
#(
   parameter crc_t POLY = 32'h04C1_1DB7
) (
   input  crc_t  crc_i,
   input  byte_t data_i,
   output crc_t  crc_o
);
   crc_t chain [BYTE_W+1];

   assign chain[0] = crc_i;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic fb;
      assign fb = chain[b][CRC_W-1] ^ data_i[b];
      assign chain[b+1] = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_o = chain[BYTE_W];
endmodule

// File: rtl/mhf_bucket.sv
module mhf_bucket
   import mhf_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  crc_t             crc_i,
   output logic [IDX_W-1:0] idx_o
);
   localparam int unsigned TOP_LSB = CRC_W - BYTE_W;

   // reversed top byte, upper IDX_W bits: idx MSB comes from the lowest top-byte bit
   for (genvar j = 0; j < IDX_W; j++) begin : g_rev
      assign idx_o[IDX_W-1-j] = ~crc_i[TOP_LSB+j];
   end
endmodule

// File: rtl/mhf_lookup.sv
module mhf_lookup #(
   parameter int unsigned TBL_W = 32,
   parameter int unsigned IDX_W = $clog2(2*TBL_W)
) (
   input  logic [TBL_W-1:0] lo_i,
   input  logic [TBL_W-1:0] hi_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             hit_o
);
   localparam int unsigned SEL_W = IDX_W - 1;

   logic [SEL_W-1:0] bit_sel;
   assign bit_sel = idx_i[SEL_W-1:0];

   always_comb begin
      if (idx_i[IDX_W-1]) hit_o = hi_i[bit_sel];
      else                hit_o = lo_i[bit_sel];
   end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int unsigned FULL_LEN = 6,
   parameter int unsigned GIGA_LEN = 5,
   parameter int unsigned TBL_W    = 32,
   parameter crc_t        POLY     = 32'h04C1_1DB7,
   parameter crc_t        SEED     = 32'hFFFF_FFFF,
   localparam int unsigned IDX_W   = $clog2(2*TBL_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   input  logic [7:0]       byte_i,
   input  logic             giga_i,
   input  logic [TBL_W-1:0] tbl_lo_i,
   input  logic [TBL_W-1:0] tbl_hi_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o,
   output logic             match_o
);
   localparam int unsigned CNT_W = $clog2(FULL_LEN + 1);

   if (IDX_W > BYTE_W) begin : g_bad_idx
      $error("bucket index wider than one CRC byte");
   end
   if (GIGA_LEN == 0 || GIGA_LEN > FULL_LEN) begin : g_bad_len
      $error("short hash length must be 1..FULL_LEN");
   end
   if ((1 << $clog2(TBL_W)) != TBL_W) begin : g_bad_tbl
      $error("table word width must be a power of two");
   end

   crc_t             crc_q, crc_nxt;
   logic [CNT_W-1:0] cnt_q, target;
   logic             active_q, giga_q, take, last;
   logic [IDX_W-1:0] idx_nxt;

   assign target = giga_q ? CNT_W'(GIGA_LEN) : CNT_W'(FULL_LEN);
   assign take   = active_q && valid_i && !start_i;
   assign last   = take && (cnt_q == target - CNT_W'(1));

   mhf_crc_step #(.POLY(POLY)) u_step (
      .crc_i (crc_q),
      .data_i(byte_i),
      .crc_o (crc_nxt)
   );

   mhf_bucket #(.IDX_W(IDX_W)) u_bucket (
      .crc_i(crc_nxt),
      .idx_o(idx_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q    <= SEED;
         cnt_q    <= '0;
         active_q <= 1'b0;
         giga_q   <= 1'b0;
         idx_o    <= '0;
         done_o   <= 1'b0;
      end else if (start_i) begin
         crc_q    <= SEED;
         cnt_q    <= '0;
         active_q <= 1'b1;
         giga_q   <= giga_i;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (take) begin
            crc_q <= crc_nxt;
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (last) begin
            active_q <= 1'b0;
            idx_o    <= idx_nxt;
            done_o   <= 1'b1;
         end
      end
   end

   mhf_lookup #(.TBL_W(TBL_W), .IDX_W(IDX_W)) u_lookup (
      .lo_i (tbl_lo_i),
      .hi_i (tbl_hi_i),
      .idx_i(idx_o),
      .hit_o(match_o)
   );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int unsigned TBL_W = 32,
   parameter int unsigned IDX_W = $clog2(2*TBL_W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             valid_i,
   input logic [TBL_W-1:0] tbl_lo_i,
   input logic [TBL_W-1:0] tbl_hi_i,
   input logic [IDX_W-1:0] idx_o,
   input logic             done_o,
   input logic             match_o
);
   logic [2*TBL_W-1:0] table_all;
   assign table_all = {tbl_hi_i, tbl_lo_i};

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(valid_i) && !$past(start_i)));

   a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(idx_o));

   a_r8_match_bit: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (match_o == table_all[idx_o]));

   a_r9_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o);
endmodule

bind mcast_hash_filter mhf_checker #(.TBL_W(TBL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .valid_i (valid_i),
   .tbl_lo_i(tbl_lo_i),
   .tbl_hi_i(tbl_hi_i),
   .idx_o   (idx_o),
   .done_o  (done_o),
   .match_o (match_o)
);

// File: tb/mcast_hash_filter_test.sv
`timescale 1ns/1ps
module mcast_hash_filter_test;
   logic        clk = 0, rst_n = 0;
   logic        start_i = 0, valid_i = 0, giga_i = 0;
   logic [7:0]  byte_i = 0;
   logic [31:0] tbl_lo_i = 0, tbl_hi_i = 0;
   logic [5:0]  idx_o;
   logic        done_o, match_o;
   int          n_chk = 0, n_bad = 0;
   bit          finished = 0;

   always #10 clk = ~clk;

   mcast_hash_filter uut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected bucket from the requirement text
   function automatic logic [5:0] model(logic [47:0] a, bit giga);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic [7:0]  top;
      logic [5:0]  r;
      int n = giga ? 5 : 6;
      for (int k = 0; k < n; k++) begin
         logic [7:0] d = a[47-8*k -: 8];
         for (int b = 0; b < 8; b++) begin
            logic fb = c[31] ^ d[b];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      c = ~c;
      top = c[31:24];
      for (int j = 0; j < 6; j++) r[5-j] = top[j];
      return r;
   endfunction

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic open_frame(bit giga);
      start_i = 1; giga_i = giga; tick(); start_i = 0;
   endtask

   task automatic push(logic [7:0] d);
      valid_i = 1; byte_i = d; tick(); valid_i = 0;
   endtask

   task automatic check_table(string req, logic [5:0] e);
      logic [63:0] t = 64'd1 << e;
      {tbl_hi_i, tbl_lo_i} = t;  #1; check(req, match_o, 1);
      {tbl_hi_i, tbl_lo_i} = ~t; #1; check(req, match_o, 0);
      tbl_lo_i = '1; tbl_hi_i = '0; #1; check(req, match_o, e < 32);
   endtask

   // full frame; done must appear only after the last hashed byte
   task automatic run_frame(string req, logic [47:0] a, bit giga, int extra);
      logic [5:0] e = model(a, giga);
      int n = giga ? 5 : 6;
      open_frame(giga);
      for (int k = 0; k < n; k++) begin
         push(a[47-8*k -: 8]);
         if (k < n-1) check({req, " early"}, done_o, 0);
      end
      check(req, done_o, 1);
      check(req, idx_o, e);
      check_table("R8", e);
      tick();
      check("R6", done_o, 0);
      for (int x = 0; x < extra; x++) begin
         push(8'hA5 ^ 8'(x));
         check("R7", done_o, 0);
         check("R7", idx_o, e);
      end
   endtask

   task automatic t_reset();
      check("R1", done_o, 0); check("R1", idx_o, 0);
      rst_n = 1; tick(); tick();
      check("R1", done_o, 0); check("R1", idx_o, 0);
   endtask

   task automatic t_sweep();
      logic [47:0] a;
      for (int i = 0; i < 24; i++) begin
         a = {8'h01, 8'h00, 8'h5E, 8'(i*7), 8'(i*13+1), 8'(i*29+3)};
         run_frame("R2 R3", a, 0, 0);
         run_frame("R4", a ^ 48'h0000_0000_00FF, 1, 0);
      end
      run_frame("R2", 48'hFFFF_FFFF_FFFF, 0, 0);
      run_frame("R3", 48'h3333_0000_0001, 0, 0);
   endtask

   task automatic t_extra();
      run_frame("R7", 48'h0100_5E7F_0102, 1, 3);
      run_frame("R7", 48'h3333_FF00_1234, 0, 2);
   endtask

   task automatic t_mode_late();
      logic [47:0] a = 48'h0100_5E10_2030;
      open_frame(1);
      giga_i = 0;
      for (int k = 0; k < 5; k++) push(a[47-8*k -: 8]);
      check("R5", done_o, 1); check("R5", idx_o, model(a, 1));
      open_frame(0);
      giga_i = 1;
      for (int k = 0; k < 5; k++) push(a[47-8*k -: 8]);
      check("R5", done_o, 0);
      push(a[7:0]);
      check("R5", done_o, 1); check("R5", idx_o, model(a, 0));
   endtask

   task automatic t_restart();
      logic [47:0] a = 48'h0100_5E44_5566;
      open_frame(0);
      push(8'h12); push(8'h34); push(8'h56);
      open_frame(0);
      for (int k = 0; k < 6; k++) push(a[47-8*k -: 8]);
      check("R9", done_o, 1); check("R9", idx_o, model(a, 0));
      // start and valid together: that byte is dropped
      start_i = 1; valid_i = 1; byte_i = 8'hEE; giga_i = 0; tick();
      start_i = 0; valid_i = 0;
      a = 48'h0100_5E01_0203;
      for (int k = 0; k < 6; k++) push(a[47-8*k -: 8]);
      check("R9", done_o, 1); check("R9", idx_o, model(a, 0));
   endtask

   task automatic t_gaps();
      logic [47:0] a = 48'h3333_0A0B_0C0D;
      open_frame(0);
      for (int k = 0; k < 6; k++) begin
         push(a[47-8*k -: 8]);
         if (k < 5) begin
            check("R10", done_o, 0);
            tick(); tick();
            check("R10", done_o, 0);
         end
      end
      check("R10", done_o, 1); check("R10", idx_o, model(a, 0));
   endtask

   initial begin
      tick();
      t_reset();
      t_sweep();
      t_extra();
      t_mode_late();
      t_restart();
      t_gaps();
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule